// File: doc/BRIEF.md
# Descriptor Ring Occupancy Controller

This block keeps the bookkeeping for one pair of descriptor rings. Software fills the input ring and hardware drains it; hardware fills the output ring and software drains it. The block holds both ring sizes. It tracks how many input slots software may still fill, how many jobs are queued for hardware, how many are in flight, and how many output slots hold results. It also owns the input read index and the output write index.

Software reports progress only as counts. It writes how many entries it has added to the input ring and how many results it has taken from the output ring. Hardware reports one strobe per consumed input entry and one per produced result. A count that would overfill or underflow a ring is rejected and recorded as a typed error. A completion interrupt follows produced results. A reset command halts the ring in two phases: first a busy phase while in-flight jobs drain, then a complete phase in which the ring is empty.

Top module: `jr_occupancy`

## Requirements
- R1: After reset, every count, index, size and status field is zero and `irq` is low.
- R2: A size write loads both sizes (SIZE_W bits, entry counts). On the next cycle the free count equals the new input size, and the queued, full and index values are zero. The halt field returns to 0, and other strobes in that cycle are dropped. A size write during the busy halt phase is ignored.
- R3: While running, an add count N not above the free count lowers `inFree` by N and raises `inQueued` by N on the next cycle.
- R4: While running, an add count above the current free count leaves all counts unchanged and sets error bit 1 of `intStatus` with type 9 in bits 11..8.
- R5: A consume strobe while running, not stopped, and with `inQueued` non-zero moves one job into flight. It lowers `inQueued` by one, raises `inFree` by one and advances `inRdIdx`, which wraps to 0 after input size minus 1. Otherwise the strobe is ignored.
- R6: A produce strobe, outside the complete phase, with a job in flight and `outFull` below the output size, raises `outFull` by one and sets pending bit 0 of `intStatus`. It advances `outWrIdx`, which wraps at the output size. Otherwise the strobe is ignored.
- R7: A remove count N (allowed while running or busy) not above `outFull` lowers it by N. A larger N leaves counts unchanged and records type 8. If an add overflow occurs in the same cycle, type 9 wins.
- R8: Writing 1 to bit 0 of the clear port clears the pending bit, and writing 1 to bit 1 clears the error bit and type. A new event in the same cycle wins over the clear.
- R9: `irq` is high when the pending bit is set and `cfgIntMask` is low, or whenever the error bit is set.
- R10: With `cfgStopOnErr` high and the error bit set, consume strobes are ignored.
- R11: A reset command outside the busy phase sets the halt field (bits 3..2) to 1 on the next cycle. While busy, adds and consumes are ignored, and produces and removes still act.
- R12: In the first busy cycle with no job in flight, the block moves to halt field 2. It then shows `inFree` equal to the input size and zero queued, full and index values. It stays there until a size write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sizeWe | input | 1 | Load both ring sizes |
| inSizeIn | input | SIZE_W | New input ring size |
| outSizeIn | input | SIZE_W | New output ring size |
| addWe | input | 1 | Software jobs-added write |
| addCount | input | SIZE_W | Number of entries added |
| rmvWe | input | 1 | Software jobs-removed write |
| rmvCount | input | SIZE_W | Number of results removed |
| hwConsume | input | 1 | Hardware took one input entry |
| hwProduce | input | 1 | Hardware wrote one result |
| cmdReset | input | 1 | Ring reset command (command bit 0) |
| intClrWe | input | 1 | Interrupt status clear write |
| intClrData | input | 2 | Write-1-to-clear bits: 0 pending, 1 error |
| cfgIntMask | input | 1 | Masks the completion interrupt |
| cfgStopOnErr | input | 1 | Stop consuming while an error is set |
| inFree | output | SIZE_W | Input slots free for software |
| inQueued | output | SIZE_W | Input entries waiting for hardware |
| outFull | output | SIZE_W | Output slots holding results |
| inRdIdx | output | SIZE_W | Hardware input read index |
| outWrIdx | output | SIZE_W | Hardware output write index |
| intStatus | output | 12 | Bit0 pending, bit1 error, 3..2 halt, 11..8 error type |
| irq | output | 1 | Interrupt request |

## Verification
A wrong credit count in this block shows at the ports on the clock after the event that corrupts it. `inFree`, `inQueued` or `outFull` then stops matching a behavioural model that adds and removes jobs by integer arithmetic. An index that wraps at the wrong place shows on the first step past the ring end. A lost in-flight job shows later: the busy halt phase either never finishes, or finishes while results are still owed. The bench therefore compares every output on every cycle. It also drives long random runs that mix halts, size reloads and overflows.

// File: rtl/jr_occ_pkg.sv
package jr_occ_pkg;

  localparam int STATUS_W = 12;

  typedef enum logic [1:0] {
    HALT_RUN  = 2'd0,
    HALT_BUSY = 2'd1,
    HALT_DONE = 2'd2
  } haltStateT;

  localparam logic [3:0] ERR_NONE    = 4'd0;
  localparam logic [3:0] ERR_RMV_OVF = 4'd8;
  localparam logic [3:0] ERR_ADD_OVF = 4'd9;

  typedef struct packed {
    logic loadSize;
    logic addJobs;
    logic rmvJobs;
    logic consume;
    logic produce;
    logic clearRing;
  } ringStrobeT;

endpackage

// File: rtl/jr_wrap_index.sv
module jr_wrap_index #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] idx
);

  logic [W:0] nextIdx;

  always_comb begin
    nextIdx = {1'b0, idx} + {{W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (clear) begin
      idx <= '0;
    end else if (step) begin
      if (nextIdx >= {1'b0, limit}) idx <= '0;
      else                          idx <= nextIdx[W-1:0];
    end
  end

endmodule

// File: rtl/jr_occ_datapath.sv
module jr_occ_datapath
  import jr_occ_pkg::*;
#(
  parameter int SIZE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobeT        strobe,
  input  logic [SIZE_W-1:0] inSizeIn,
  input  logic [SIZE_W-1:0] outSizeIn,
  input  logic [SIZE_W-1:0] addCount,
  input  logic [SIZE_W-1:0] rmvCount,
  output logic [SIZE_W-1:0] inFree,
  output logic [SIZE_W-1:0] inQueued,
  output logic [SIZE_W-1:0] inFlight,
  output logic [SIZE_W-1:0] outFull,
  output logic [SIZE_W-1:0] outSize,
  output logic [SIZE_W-1:0] inRdIdx,
  output logic [SIZE_W-1:0] outWrIdx
);

  localparam int NUM_IDX = 2;

  logic [SIZE_W-1:0] inSizeQ;
  logic [SIZE_W-1:0] addAmt;
  logic [SIZE_W-1:0] rmvAmt;
  logic [SIZE_W-1:0] oneIn;
  logic [SIZE_W-1:0] oneOut;
  logic [NUM_IDX-1:0] stepVec;
  logic [SIZE_W-1:0] limitVec [NUM_IDX];
  logic [SIZE_W-1:0] idxVec   [NUM_IDX];
  logic idxClear;

  always_comb begin
    addAmt      = strobe.addJobs ? addCount : '0;
    rmvAmt      = strobe.rmvJobs ? rmvCount : '0;
    oneIn       = {{(SIZE_W-1){1'b0}}, strobe.consume};
    oneOut      = {{(SIZE_W-1){1'b0}}, strobe.produce};
    stepVec     = {strobe.produce, strobe.consume};
    limitVec[0] = inSizeQ;
    limitVec[1] = outSize;
    idxClear    = strobe.loadSize | strobe.clearRing;
    inRdIdx     = idxVec[0];
    outWrIdx    = idxVec[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSizeQ  <= '0;
      outSize  <= '0;
      inFree   <= '0;
      inQueued <= '0;
      inFlight <= '0;
      outFull  <= '0;
    end else if (strobe.loadSize) begin
      inSizeQ  <= inSizeIn;
      outSize  <= outSizeIn;
      inFree   <= inSizeIn;
      inQueued <= '0;
      inFlight <= '0;
      outFull  <= '0;
    end else if (strobe.clearRing) begin
      inFree   <= inSizeQ;
      inQueued <= '0;
      inFlight <= '0;
      outFull  <= '0;
    end else begin
      inFree   <= inFree - addAmt + oneIn;
      inQueued <= inQueued + addAmt - oneIn;
      inFlight <= inFlight + oneIn - oneOut;
      outFull  <= outFull + oneOut - rmvAmt;
    end
  end

  generate
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
      jr_wrap_index #(.W(SIZE_W)) u_idx (
        .clk   (clk),
        .rstN  (rstN),
        .clear (idxClear),
        .step  (stepVec[g]),
        .limit (limitVec[g]),
        .idx   (idxVec[g])
      );
    end
  endgenerate

endmodule

// File: rtl/jr_occ_control.sv
module jr_occ_control
  import jr_occ_pkg::*;
#(
  parameter int SIZE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sizeWe,
  input  logic                addWe,
  input  logic [SIZE_W-1:0]   addCount,
  input  logic                rmvWe,
  input  logic [SIZE_W-1:0]   rmvCount,
  input  logic                hwConsume,
  input  logic                hwProduce,
  input  logic                cmdReset,
  input  logic                intClrWe,
  input  logic [1:0]          intClrData,
  input  logic                cfgIntMask,
  input  logic                cfgStopOnErr,
  input  logic [SIZE_W-1:0]   inFree,
  input  logic [SIZE_W-1:0]   inQueued,
  input  logic [SIZE_W-1:0]   inFlight,
  input  logic [SIZE_W-1:0]   outFull,
  input  logic [SIZE_W-1:0]   outSize,
  output ringStrobeT          strobe,
  output logic [STATUS_W-1:0] intStatus,
  output logic                irq
);

  haltStateT haltState;
  logic      pending;
  logic      errFlag;
  logic [3:0] errType;
  logic running;
  logic rmvAllowed;
  logic loadOk;
  logic addOvf;
  logic rmvOvf;
  logic ringStopped;

  always_comb begin
    running     = (haltState == HALT_RUN);
    rmvAllowed  = (haltState != HALT_DONE);
    loadOk      = sizeWe && (haltState != HALT_BUSY);
    ringStopped = cfgStopOnErr && errFlag;
    addOvf      = !loadOk && addWe && running && (addCount > inFree);
    rmvOvf      = !loadOk && rmvWe && rmvAllowed && (rmvCount > outFull);

    strobe.loadSize  = loadOk;
    strobe.addJobs   = !loadOk && addWe && running && !addOvf;
    strobe.rmvJobs   = !loadOk && rmvWe && rmvAllowed && !rmvOvf;
    strobe.consume   = !loadOk && hwConsume && running && !ringStopped
                       && (inQueued != '0);
    strobe.produce   = !loadOk && hwProduce && (haltState != HALT_DONE)
                       && (inFlight != '0) && (outFull != outSize);
    strobe.clearRing = !loadOk && (haltState == HALT_BUSY) && (inFlight == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltState <= HALT_RUN;
    end else if (loadOk) begin
      haltState <= HALT_RUN;
    end else if (strobe.clearRing) begin
      haltState <= HALT_DONE;
    end else if (cmdReset && (haltState != HALT_BUSY)) begin
      haltState <= HALT_BUSY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      errType <= ERR_NONE;
    end else if (addOvf) begin
      errFlag <= 1'b1;
      errType <= ERR_ADD_OVF;
    end else if (rmvOvf) begin
      errFlag <= 1'b1;
      errType <= ERR_RMV_OVF;
    end else if (intClrWe && intClrData[1]) begin
      errFlag <= 1'b0;
      errType <= ERR_NONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.produce) begin
      pending <= 1'b1;
    end else if (intClrWe && intClrData[0]) begin
      pending <= 1'b0;
    end
  end

  always_comb begin
    intStatus = {errType, 4'b0000, haltState, errFlag, pending};
    irq       = (pending && !cfgIntMask) || errFlag;
  end

endmodule

// File: rtl/jr_occupancy.sv
module jr_occupancy
  import jr_occ_pkg::*;
#(
  parameter int SIZE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sizeWe,
  input  logic [SIZE_W-1:0]   inSizeIn,
  input  logic [SIZE_W-1:0]   outSizeIn,
  input  logic                addWe,
  input  logic [SIZE_W-1:0]   addCount,
  input  logic                rmvWe,
  input  logic [SIZE_W-1:0]   rmvCount,
  input  logic                hwConsume,
  input  logic                hwProduce,
  input  logic                cmdReset,
  input  logic                intClrWe,
  input  logic [1:0]          intClrData,
  input  logic                cfgIntMask,
  input  logic                cfgStopOnErr,
  output logic [SIZE_W-1:0]   inFree,
  output logic [SIZE_W-1:0]   inQueued,
  output logic [SIZE_W-1:0]   outFull,
  output logic [SIZE_W-1:0]   inRdIdx,
  output logic [SIZE_W-1:0]   outWrIdx,
  output logic [STATUS_W-1:0] intStatus,
  output logic                irq
);

  ringStrobeT        strobe;
  logic [SIZE_W-1:0] inFlight;
  logic [SIZE_W-1:0] outSize;

  jr_occ_control #(.SIZE_W(SIZE_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sizeWe       (sizeWe),
    .addWe        (addWe),
    .addCount     (addCount),
    .rmvWe        (rmvWe),
    .rmvCount     (rmvCount),
    .hwConsume    (hwConsume),
    .hwProduce    (hwProduce),
    .cmdReset     (cmdReset),
    .intClrWe     (intClrWe),
    .intClrData   (intClrData),
    .cfgIntMask   (cfgIntMask),
    .cfgStopOnErr (cfgStopOnErr),
    .inFree       (inFree),
    .inQueued     (inQueued),
    .inFlight     (inFlight),
    .outFull      (outFull),
    .outSize      (outSize),
    .strobe       (strobe),
    .intStatus    (intStatus),
    .irq          (irq)
  );

  jr_occ_datapath #(.SIZE_W(SIZE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inSizeIn  (inSizeIn),
    .outSizeIn (outSizeIn),
    .addCount  (addCount),
    .rmvCount  (rmvCount),
    .inFree    (inFree),
    .inQueued  (inQueued),
    .inFlight  (inFlight),
    .outFull   (outFull),
    .outSize   (outSize),
    .inRdIdx   (inRdIdx),
    .outWrIdx  (outWrIdx)
  );

endmodule

// File: rtl/jr_occ_checker.sv
module jr_occ_checker #(
  parameter int SIZE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              sizeWe,
  input logic [SIZE_W-1:0] inSizeIn,
  input logic [SIZE_W-1:0] outSizeIn,
  input logic              addWe,
  input logic [SIZE_W-1:0] addCount,
  input logic              rmvWe,
  input logic [SIZE_W-1:0] rmvCount,
  input logic              cmdReset,
  input logic              cfgStopOnErr,
  input logic [SIZE_W-1:0] inFree,
  input logic [SIZE_W-1:0] inQueued,
  input logic [SIZE_W-1:0] outFull,
  input logic [SIZE_W-1:0] inRdIdx,
  input logic [SIZE_W-1:0] outWrIdx,
  input logic [11:0]       intStatus
);

  logic [SIZE_W-1:0] shInSize;
  logic [SIZE_W-1:0] shOutSize;
  logic [1:0]        haltF;

  assign haltF = intStatus[3:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shInSize  <= '0;
      shOutSize <= '0;
    end else if (sizeWe && haltF != 2'd1) begin
      shInSize  <= inSizeIn;
      shOutSize <= outSizeIn;
    end
  end

  p_credit_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, inFree} + {1'b0, inQueued}) <= {1'b0, shInSize});

  p_full_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    outFull <= shOutSize);

  p_add_ovf_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addWe && !sizeWe && haltF == 2'd0 && addCount > inFree)
    |=> (intStatus[1] && intStatus[11:8] == 4'd9));

  p_rmv_ovf_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rmvWe && !addWe && !sizeWe && haltF != 2'd2 && rmvCount > outFull)
    |=> (intStatus[1] && intStatus[11:8] == 4'd8));

  p_rd_idx_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (shInSize != '0) |-> (inRdIdx < shInSize));

  p_wr_idx_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (shOutSize != '0) |-> (outWrIdx < shOutSize));

  p_fill_sets_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outFull > $past(outFull)) |-> intStatus[0]);

  p_halt_enter_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReset && !sizeWe && haltF != 2'd1) |=> (haltF == 2'd1));

  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    (haltF == 2'd1) |=> (haltF != 2'd0));

  p_done_empty_r12: assert property (@(posedge clk) disable iff (!rstN)
    (haltF == 2'd2 && $past(haltF) == 2'd1)
    |-> (inFree == shInSize && inQueued == '0 && outFull == '0
         && inRdIdx == '0 && outWrIdx == '0));

  p_stop_on_err_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStopOnErr && intStatus[1] && !sizeWe && haltF == 2'd0)
    |=> (inQueued >= $past(inQueued)));

endmodule

bind jr_occupancy jr_occ_checker #(.SIZE_W(SIZE_W)) u_occ_check (
  .clk          (clk),
  .rstN         (rstN),
  .sizeWe       (sizeWe),
  .inSizeIn     (inSizeIn),
  .outSizeIn    (outSizeIn),
  .addWe        (addWe),
  .addCount     (addCount),
  .rmvWe        (rmvWe),
  .rmvCount     (rmvCount),
  .cmdReset     (cmdReset),
  .cfgStopOnErr (cfgStopOnErr),
  .inFree       (inFree),
  .inQueued     (inQueued),
  .outFull      (outFull),
  .inRdIdx      (inRdIdx),
  .outWrIdx     (outWrIdx),
  .intStatus    (intStatus)
);

// File: tb/test_jr_occupancy.sv
module test_jr_occupancy;

  localparam int SW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sizeWe = 0, addWe = 0, rmvWe = 0, hwConsume = 0, hwProduce = 0;
  logic cmdReset = 0, intClrWe = 0, cfgIntMask = 0, cfgStopOnErr = 0;
  logic [SW-1:0] inSizeIn = '0, outSizeIn = '0, addCount = '0, rmvCount = '0;
  logic [1:0] intClrData = '0;
  logic [SW-1:0] inFree, inQueued, outFull, inRdIdx, outWrIdx;
  logic [11:0] intStatus;
  logic irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  int mInSize = 0, mOutSize = 0, mFree = 0, mQueued = 0, mFlight = 0, mFull = 0;
  int mRd = 0, mWr = 0, mHalt = 0, mPend = 0, mErr = 0, mType = 0;

  jr_occupancy #(.SIZE_W(SW)) i_jr_occupancy (
    .clk(clk), .rstN(rstN), .sizeWe(sizeWe), .inSizeIn(inSizeIn),
    .outSizeIn(outSizeIn), .addWe(addWe), .addCount(addCount),
    .rmvWe(rmvWe), .rmvCount(rmvCount), .hwConsume(hwConsume),
    .hwProduce(hwProduce), .cmdReset(cmdReset), .intClrWe(intClrWe),
    .intClrData(intClrData), .cfgIntMask(cfgIntMask),
    .cfgStopOnErr(cfgStopOnErr), .inFree(inFree), .inQueued(inQueued),
    .outFull(outFull), .inRdIdx(inRdIdx), .outWrIdx(outWrIdx),
    .intStatus(intStatus), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    int nFree, nQueued, nFlight, nFull, nRd, nWr, nHalt, nPend, nErr, nType;
    bit run, load, aOvf, rOvf, aOk, rOk, cons, prod, clr;
    if (!rstN) begin
      mInSize = 0; mOutSize = 0; mFree = 0; mQueued = 0; mFlight = 0; mFull = 0;
      mRd = 0; mWr = 0; mHalt = 0; mPend = 0; mErr = 0; mType = 0;
    end else begin
      run  = (mHalt == 0);
      load = sizeWe && (mHalt != 1);
      aOvf = !load && addWe && run && (int'(addCount) > mFree);
      rOvf = !load && rmvWe && (mHalt != 2) && (int'(rmvCount) > mFull);
      aOk  = !load && addWe && run && !aOvf;
      rOk  = !load && rmvWe && (mHalt != 2) && !rOvf;
      cons = !load && hwConsume && run && !(cfgStopOnErr && mErr == 1) && mQueued > 0;
      prod = !load && hwProduce && (mHalt != 2) && mFlight > 0 && mFull < mOutSize;
      clr  = !load && (mHalt == 1) && mFlight == 0;
      nFree = mFree; nQueued = mQueued; nFlight = mFlight; nFull = mFull;
      nRd = mRd; nWr = mWr; nHalt = mHalt; nPend = mPend; nErr = mErr; nType = mType;
      if (load) begin
        mInSize = int'(inSizeIn); mOutSize = int'(outSizeIn);
        nFree = mInSize; nQueued = 0; nFlight = 0; nFull = 0; nRd = 0; nWr = 0; nHalt = 0;
      end else if (clr) begin
        nFree = mInSize; nQueued = 0; nFlight = 0; nFull = 0; nRd = 0; nWr = 0; nHalt = 2;
      end else begin
        if (aOk) begin nFree -= int'(addCount); nQueued += int'(addCount); end
        if (rOk) nFull -= int'(rmvCount);
        if (cons) begin
          nFree++; nQueued--; nFlight++;
          nRd = (mRd + 1 >= mInSize) ? 0 : mRd + 1;
        end
        if (prod) begin
          nFull++; nFlight--;
          nWr = (mWr + 1 >= mOutSize) ? 0 : mWr + 1;
        end
        if (cmdReset && mHalt != 1) nHalt = 1;
      end
      if (aOvf) begin nErr = 1; nType = 9; end
      else if (rOvf) begin nErr = 1; nType = 8; end
      else if (intClrWe && intClrData[1]) begin nErr = 0; nType = 0; end
      if (prod) nPend = 1;
      else if (intClrWe && intClrData[0]) nPend = 0;
      mFree = nFree; mQueued = nQueued; mFlight = nFlight; mFull = nFull;
      mRd = nRd; mWr = nWr; mHalt = nHalt; mPend = nPend; mErr = nErr; mType = nType;
    end
  end

  // compare every output against the model on each falling edge
  always @(negedge clk) begin
    chk({curReq, " model inFree"}, int'(inFree), mFree);
    chk({curReq, " model inQueued"}, int'(inQueued), mQueued);
    chk({curReq, " model outFull"}, int'(outFull), mFull);
    chk({curReq, " model inRdIdx"}, int'(inRdIdx), mRd);
    chk({curReq, " model outWrIdx"}, int'(outWrIdx), mWr);
    chk({curReq, " model intStatus"}, int'(intStatus),
        (mType << 8) | (mHalt << 2) | (mErr << 1) | mPend);
    chk({curReq, " model irq"}, int'(irq),
        ((mPend == 1 && !cfgIntMask) || mErr == 1) ? 1 : 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic clrIn();
    sizeWe = 0; addWe = 0; rmvWe = 0; hwConsume = 0; hwProduce = 0;
    cmdReset = 0; intClrWe = 0; intClrData = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
    clrIn();
  endtask

  task automatic doLoad(int a, int b);
    sizeWe = 1; inSizeIn = SW'(a); outSizeIn = SW'(b); cyc();
  endtask

  task automatic doAdd(int n);
    addWe = 1; addCount = SW'(n); cyc();
  endtask

  task automatic doRmv(int n);
    rmvWe = 1; rmvCount = SW'(n); cyc();
  endtask

  task automatic doClr(int bits);
    intClrWe = 1; intClrData = 2'(bits); cyc();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    curReq = "R1";
    chk("R1 reset inFree", int'(inFree), 0);
    chk("R1 reset intStatus", int'(intStatus), 0);
    chk("R1 reset irq", int'(irq), 0);

    curReq = "R2";
    doLoad(4, 3);
    chk("R2 load inFree", int'(inFree), 4);

    curReq = "R3";
    doAdd(3);
    chk("R3 add inFree", int'(inFree), 1);
    chk("R3 add inQueued", int'(inQueued), 3);

    curReq = "R4";
    doAdd(2);
    chk("R4 ovf inFree unchanged", int'(inFree), 1);
    chk("R4 ovf type", int'(intStatus[11:8]), 9);
    curReq = "R8";
    doClr(2);
    chk("R8 error cleared", int'(intStatus[1]), 0);

    curReq = "R5";
    repeat (4) begin hwConsume = 1; cyc(); end
    chk("R5 consume queued", int'(inQueued), 0);
    chk("R5 consume rdIdx", int'(inRdIdx), 3);
    doAdd(2);
    repeat (2) begin hwConsume = 1; cyc(); end
    chk("R5 wrap rdIdx", int'(inRdIdx), 1);

    curReq = "R6";
    repeat (4) begin hwProduce = 1; cyc(); end
    chk("R6 outFull capped", int'(outFull), 3);
    chk("R6 wrap wrIdx", int'(outWrIdx), 0);
    chk("R6 pending", int'(intStatus[0]), 1);

    curReq = "R9";
    #1 chk("R9 irq unmasked", int'(irq), 1);
    cfgIntMask = 1;
    #1 chk("R9 irq masked", int'(irq), 0);
    cfgIntMask = 0;

    curReq = "R8";
    doClr(1);
    chk("R8 pending cleared", int'(intStatus[0]), 0);

    curReq = "R7";
    doRmv(4);
    chk("R7 remove ovf type", int'(intStatus[11:8]), 8);
    chk("R7 outFull unchanged", int'(outFull), 3);
    doRmv(2);
    chk("R7 remove ok", int'(outFull), 1);
    doClr(2);

    curReq = "R10";
    cfgStopOnErr = 1;
    doAdd(2);
    doAdd(100);
    hwConsume = 1; cyc();
    chk("R10 consume stopped", int'(inQueued), 2);
    doClr(2);
    hwConsume = 1; cyc();
    chk("R10 consume resumed", int'(inQueued), 1);
    cfgStopOnErr = 0;

    curReq = "R11";
    cmdReset = 1; cyc();
    chk("R11 halt busy", int'(intStatus[3:2]), 1);
    hwConsume = 1; cyc();
    doAdd(1);
    chk("R11 add ignored", int'(inFree), 3);
    chk("R11 consume ignored", int'(inQueued), 1);
    curReq = "R2";
    doLoad(8, 2);
    chk("R2 load ignored while busy", int'(intStatus[3:2]), 1);
    curReq = "R11";
    repeat (2) begin hwProduce = 1; cyc(); end
    doRmv(3);
    chk("R11 remove while busy", int'(outFull), 0);
    hwProduce = 1; cyc();
    cyc();
    curReq = "R12";
    chk("R12 halt done", int'(intStatus[3:2]), 2);
    chk("R12 free restored", int'(inFree), 4);
    chk("R12 rdIdx cleared", int'(inRdIdx), 0);
    chk("R12 outFull cleared", int'(outFull), 0);

    curReq = "R2";
    doLoad(8, 2);
    chk("R2 reload run", int'(intStatus[3:2]), 0);
    chk("R2 reload inFree", int'(inFree), 8);

    curReq = "R3-random";
    for (int i = 0; i < 4000; i++) begin
      addWe      = ($urandom % 4) == 0;
      addCount   = SW'($urandom % 7);
      rmvWe      = ($urandom % 4) == 0;
      rmvCount   = SW'($urandom % 4);
      hwConsume  = ($urandom % 2) == 0;
      hwProduce  = ($urandom % 2) == 0;
      cmdReset   = ($urandom % 150) == 0;
      sizeWe     = ($urandom % 200) == 0;
      inSizeIn   = SW'(1 + $urandom % 9);
      outSizeIn  = SW'(1 + $urandom % 6);
      intClrWe   = ($urandom % 8) == 0;
      intClrData = 2'($urandom % 4);
      if (($urandom % 300) == 0) cfgStopOnErr = ~cfgStopOnErr;
      if (($urandom % 100) == 0) cfgIntMask = ~cfgIntMask;
      cyc();
    end

    repeat (2) @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule